// File: doc/BRIEF.md
# Memory Bitfield Access Unit

This unit performs bitfield operations on a big-endian memory that is addressed by byte. A request supplies a base byte address, a signed 32-bit bit offset, a 5-bit width code, an operation code and a source value. The unit works out the first byte the field touches and the bit position inside that byte. It then reads every byte the field overlaps, one at a time, over a byte-wide port that allows one request in flight. The field can cover one to five bytes.

The unit supports seven operations: unsigned extract, signed extract, insert, change, clear, set and find-first-one. Insert, change, clear and set then write the touched bytes back through the same port. Each operation ends with a one-cycle `done` pulse. At that point two values are valid: a result value, and a left-justified value from which a processor can derive condition flags. Both are held until the next operation starts.

Top module: `bfmem_unit`

## Requirements
- R1: `width_sel` is 5 bits wide. Code 0 selects a 32-bit field and codes 1 to 31 select that many bits.
- R2: The first byte touched is `base_addr + floor(bit_ofs/8)`, with `bit_ofs` treated as signed. The bit position inside that byte is `bit_ofs mod 8` (0..7), so a negative offset reaches bytes below the base.
- R3: An operation reads exactly `floor((pos + width - 1)/8) + 1` bytes, starting at the first byte, in ascending address order. Each request keeps `mem_addr` and `mem_we` stable until `mem_ack`.
- R4: Op code 0 (unsigned extract) returns the field zero-extended in `result`. Field bit 0 is the most significant bit of the first byte. `flag_src` is the field left-justified in 32 bits.
- R5: Op code 1 (signed extract) returns the field sign-extended to 32 bits. `flag_src` is the same as for R4.
- R6: Op code 2 (insert) replaces the field in memory with the low `width` bits of `src_val` and leaves the other bits of the touched bytes unchanged. `result` is those bits zero-extended, and `flag_src` is `src_val` shifted left by 32 minus width.
- R7: Op codes 3 (change), 4 (clear) and 5 (set) invert, zero or fill the field in memory and leave the other bits unchanged. `result` is the prior field zero-extended, and `flag_src` is the prior field left-justified.
- R8: Op code 6 (find-first-one) returns `bit_ofs` plus the number of leading zeros inside the field, or `bit_ofs` plus the width when the field is all zeros. `flag_src` is the field left-justified.
- R9: Op codes 2 to 5 write back the same bytes that were read, in ascending order, after all the reads. Op codes 0, 1 and 6 issue no write.
- R10: After reset `done` and `mem_req` are 0. `done` is a one-cycle pulse, and `result` and `flag_src` are valid from that cycle until the next operation. `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code |
| base_addr | input | AW | Base byte address |
| bit_ofs | input | 32 | Signed bit offset from the base |
| width_sel | input | LW | Field width, 0 meaning FW |
| src_val | input | FW | Value to insert |
| done | output | 1 | Completion pulse |
| result | output | FW | Operation result |
| flag_src | output | FW | Left-justified value for flag generation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |

## Verification
Two situations are the hardest to reach from the ports. The first is a field that spans five bytes and starts below the base address, because it needs a negative offset, a nonzero bit position and a near-full width all at once. The second is a find-first-one over a field that is entirely zero. The bench sweeps every width code against offsets of -13, -8, -1, 0, 1, 7, 9 and 22 for every operation, which covers both signs and every byte count from one to five. One memory fill in six is all zeros, so find-first-one meets empty fields at every width. A reference bit model checks the byte sequence, the result, the flag value and the whole memory image after each operation.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    OP_EXTU = 3'd0,
    OP_EXTS = 3'd1,
    OP_INS  = 3'd2,
    OP_CHG  = 3'd3,
    OP_CLR  = 3'd4,
    OP_SET  = 3'd5,
    OP_FFO  = 3'd6
  } bf_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE
  } bf_st_e;

  function automatic logic op_modifies(bf_op_e o);
    return (o == OP_INS) || (o == OP_CHG) || (o == OP_CLR) || (o == OP_SET);
  endfunction
endpackage

// File: rtl/bf_locate.sv
module bf_locate #(
  parameter int AW = 16,
  parameter int FW = 32,
  localparam int LW = $clog2(FW),
  localparam int NB = FW / 8 + 1,
  localparam int IW = $clog2(NB)
) (
  input  logic [AW-1:0] base,
  input  logic [31:0]   ofs,
  input  logic [LW-1:0] wsel,
  output logic [AW-1:0] addr0,
  output logic [2:0]    bpos,
  output logic [LW:0]   wlen,
  output logic [IW-1:0] last
);
  logic [31:0]   byte_ofs;
  logic [LW+1:0] span;

  // floor division: arithmetic shift rounds toward minus infinity
  assign byte_ofs = $signed(ofs) >>> 3;
  assign addr0    = AW'(32'(base) + byte_ofs);
  assign bpos     = ofs[2:0];
  assign wlen     = (wsel == '0) ? (LW+1)'(FW) : {1'b0, wsel};
  assign span     = (LW+2)'(bpos) + (LW+2)'(wlen) - (LW+2)'(1);
  assign last     = IW'(span >> 3);
endmodule

// File: rtl/bf_alu.sv
module bf_alu
  import bf_pkg::*;
#(
  parameter int FW = 32,
  localparam int LW  = $clog2(FW),
  localparam int WIN = FW + 8
) (
  input  logic [WIN-1:0] win,
  input  logic [2:0]     bpos,
  input  logic [LW:0]    wlen,
  input  bf_op_e         op,
  input  logic [FW-1:0]  src,
  input  logic [FW-1:0]  ofs,
  output logic [WIN-1:0] new_win,
  output logic [FW-1:0]  result,
  output logic [FW-1:0]  flag
);
  logic [WIN-1:0] shifted, win_mask, ins_win;
  logic [LW:0]    rsh, lead;
  logic [FW-1:0]  lj_mask, field_lj, uext, sext, ins_lj;
  logic           found;

  assign shifted  = win << bpos;
  assign rsh      = (LW+1)'(FW) - wlen;
  assign lj_mask  = {FW{1'b1}} << rsh;
  assign field_lj = FW'(shifted >> 8) & lj_mask;
  assign uext     = field_lj >> rsh;
  assign sext     = FW'($signed(field_lj) >>> rsh);
  assign ins_lj   = src << rsh;
  assign win_mask = {lj_mask, 8'h00} >> bpos;
  assign ins_win  = {ins_lj, 8'h00} >> bpos;

  always_comb begin
    found = 1'b0;
    lead  = wlen;
    for (int i = 0; i < FW; i++) begin
      if (!found && field_lj[FW-1-i]) begin
        found = 1'b1;
        lead  = (LW+1)'(i);
      end
    end
  end

  always_comb begin
    new_win = win;
    result  = uext;
    flag    = field_lj;
    unique case (op)
      OP_EXTS: result = sext;
      OP_INS: begin
        new_win = (win & ~win_mask) | ins_win;
        result  = ins_lj >> rsh;
        flag    = ins_lj;
      end
      OP_CHG:  new_win = win ^ win_mask;
      OP_CLR:  new_win = win & ~win_mask;
      OP_SET:  new_win = win | win_mask;
      OP_FFO:  result  = ofs + FW'(lead);
      default: result  = uext;
    endcase
  end
endmodule

// File: rtl/bfmem_unit.sv
module bfmem_unit
  import bf_pkg::*;
#(
  parameter int AW = 16,
  parameter int FW = 32,
  localparam int LW  = $clog2(FW),
  localparam int NB  = FW / 8 + 1,
  localparam int IW  = $clog2(NB),
  localparam int WIN = FW + 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   bit_ofs,
  input  logic [LW-1:0] width_sel,
  input  logic [FW-1:0] src_val,
  output logic          done,
  output logic [FW-1:0] result,
  output logic [FW-1:0] flag_src,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);
  logic [1:0]     rsync_q;
  logic           rst_int_n;
  bf_st_e         st_q, st_d;
  bf_op_e         op_q, op_d;
  logic [AW-1:0]  base_q, base_d;
  logic [31:0]    ofs_q, ofs_d;
  logic [LW-1:0]  wsel_q, wsel_d;
  logic [FW-1:0]  src_q, src_d, res_q, res_d, flag_q, flag_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [WIN-1:0] win_q, win_d, new_win;
  logic           done_q, done_d;
  logic [AW-1:0]  addr0;
  logic [2:0]     bpos;
  logic [LW:0]    wlen;
  logic [IW-1:0]  last;
  logic [FW-1:0]  alu_res, alu_flag;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  bf_locate #(.AW(AW), .FW(FW)) u_loc (
    .base(base_q), .ofs(ofs_q), .wsel(wsel_q),
    .addr0(addr0), .bpos(bpos), .wlen(wlen), .last(last)
  );

  bf_alu #(.FW(FW)) u_alu (
    .win(win_q), .bpos(bpos), .wlen(wlen), .op(op_q), .src(src_q),
    .ofs(ofs_q[FW-1:0]), .new_win(new_win), .result(alu_res), .flag(alu_flag)
  );

  always_comb begin
    st_d   = st_q;   op_d   = op_q;   base_d = base_q; ofs_d  = ofs_q;
    wsel_d = wsel_q; src_d  = src_q;  idx_d  = idx_q;  win_d  = win_q;
    res_d  = res_q;  flag_d = flag_q; done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        op_d   = bf_op_e'(op);
        base_d = base_addr;
        ofs_d  = bit_ofs;
        wsel_d = width_sel;
        src_d  = src_val;
        idx_d  = '0;
        win_d  = '0;
        st_d   = ST_READ;
      end
      ST_READ: if (mem_ack) begin
        for (int b = 0; b < NB; b++)
          if (idx_q == IW'(b)) win_d[WIN-1-8*b -: 8] = mem_rdata;
        if (idx_q == last) begin
          idx_d = '0;
          st_d  = ST_CALC;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      ST_CALC: begin
        res_d  = alu_res;
        flag_d = alu_flag;
        if (op_modifies(op_q)) begin
          st_d = ST_WRITE;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_WRITE: if (mem_ack) begin
        if (idx_q == last) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;  op_q   <= OP_EXTU; base_q <= '0; ofs_q  <= '0;
      wsel_q <= '0;       src_q  <= '0;      idx_q  <= '0; win_q  <= '0;
      res_q  <= '0;       flag_q <= '0;      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;     op_q   <= op_d;    base_q <= base_d; ofs_q  <= ofs_d;
      wsel_q <= wsel_d;   src_q  <= src_d;   idx_q  <= idx_d;  win_q  <= win_d;
      res_q  <= res_d;    flag_q <= flag_d;  done_q <= done_d;
    end
  end

  always_comb begin
    mem_wdata = 8'h00;
    for (int b = 0; b < NB; b++)
      if (idx_q == IW'(b)) mem_wdata = new_win[WIN-1-8*b -: 8];
  end

  assign mem_req  = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we   = (st_q == ST_WRITE);
  assign mem_addr = addr0 + AW'(idx_q);
  assign done     = done_q;
  assign result   = res_q;
  assign flag_src = flag_q;
endmodule

// File: rtl/bf_checks.sv
module bf_checks #(
  parameter int AW = 16,
  parameter int FW = 32,
  localparam int LW = $clog2(FW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [FW-1:0] result,
  input logic [2:0]    op_q,
  input logic [31:0]   ofs_q,
  input logic [LW-1:0] wsel_q
);
  logic [LW:0] wl_c;
  assign wl_c = (wsel_q == '0) ? (LW+1)'(FW) : {1'b0, wsel_q};

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || (mem_we != $past(mem_we)) ||
                           (mem_addr == $past(mem_addr) + AW'(1)));

  p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && (op_q inside {3'd2, 3'd3, 3'd4, 3'd5}));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_extu_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 3'd0 && wsel_q != '0 |-> (result >> wsel_q) == '0);

  p_ffo_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 3'd6 |-> FW'(result - ofs_q[FW-1:0]) <= FW'(wl_c));
endmodule

bind bfmem_unit bf_checks #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .done(done), .result(result),
  .op_q(op_q), .ofs_q(ofs_q), .wsel_q(wsel_q)
);

// File: tb/sim_bfmem_unit.sv
module sim_bfmem_unit;
  localparam int AW = 16;
  localparam int FW = 32;
  localparam int LW = 5;
  localparam int BASE = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, done, mem_req, mem_we, mem_ack;
  logic [2:0]    op;
  logic [AW-1:0] base, mem_addr;
  logic [31:0]   ofs;
  logic [LW-1:0] wsel;
  logic [FW-1:0] src, result, flag;
  logic [7:0]    mem_wdata, mem_rdata;

  bfmem_unit #(.AW(AW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base),
    .bit_ofs(ofs), .width_sel(wsel), .src_val(src), .done(done),
    .result(result), .flag_src(flag), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  logic [7:0]    mem [64];
  logic          fill_req, clr_cnt;
  int            fill_seed, rd_cnt, wr_cnt, seq_err;
  logic [AW-1:0] exp_start, exp_rd, exp_wr;
  int            n_chk, n_err;

  function automatic logic [7:0] pat(int i, int k);
    if (k % 6 == 0) return 8'h00;
    return 8'(i * 29 + k * 13) ^ 8'(k >> 2);
  endfunction

  // byte memory: ack one cycle after a request, one completion per request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[5:0]];
      end
    end
    if (fill_req)
      for (int i = 0; i < 64; i++) mem[i] <= pat(i, fill_seed);
    if (clr_cnt) begin
      rd_cnt <= 0; wr_cnt <= 0; seq_err <= 0;
      exp_rd <= exp_start; exp_wr <= exp_start;
    end else if (mem_req && mem_ack) begin
      if (mem_we) begin
        if (mem_addr != exp_wr || rd_cnt == 0) seq_err <= seq_err + 1;
        exp_wr <= exp_wr + 1'b1;
        wr_cnt <= wr_cnt + 1;
      end else begin
        if (mem_addr != exp_rd || wr_cnt != 0) seq_err <= seq_err + 1;
        exp_rd <= exp_rd + 1'b1;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(int k, logic [2:0] o, int of, int w, logic [31:0] s, bit poke);
    logic [7:0]  gold [64];
    int          wl, abs_b, first, last, n, jf, a, cnt;
    logic [31:0] f, eres, eflag;
    logic        b, modify;
    string       tag;
    wl    = (w == 0) ? 32 : w;
    abs_b = BASE * 8 + of;
    first = abs_b >>> 3;
    last  = (abs_b + wl - 1) >>> 3;
    n     = last - first + 1;
    @(negedge clk);
    fill_req = 1'b1; fill_seed = k; clr_cnt = 1'b1; exp_start = AW'(first);
    @(negedge clk);
    fill_req = 1'b0; clr_cnt = 1'b0;
    for (int i = 0; i < 64; i++) gold[i] = pat(i, k);
    f = 0; jf = -1;
    for (int j = 0; j < wl; j++) begin
      a = abs_b + j;
      b = gold[a >> 3][7 - (a % 8)];
      f = {f[30:0], b};
      if (b && jf < 0) jf = j;
    end
    eflag  = 32'(64'(f) << (32 - wl));
    eres   = f;
    modify = (o >= 3'd2 && o <= 3'd5);
    case (o)
      3'd1: if (wl < 32 && f[wl-1]) eres = f | ~((32'd1 << wl) - 1);
      3'd2: begin
        eres  = s & ((32'd1 << wl) - 1);
        eflag = 32'(64'(s) << (32 - wl));
      end
      3'd6: eres = 32'(of + ((jf < 0) ? wl : jf));
      default: ;
    endcase
    if (modify)
      for (int j = 0; j < wl; j++) begin
        a = abs_b + j;
        case (o)
          3'd2: gold[a >> 3][7 - (a % 8)] = s[wl - 1 - j];
          3'd3: gold[a >> 3][7 - (a % 8)] = ~gold[a >> 3][7 - (a % 8)];
          3'd4: gold[a >> 3][7 - (a % 8)] = 1'b0;
          default: gold[a >> 3][7 - (a % 8)] = 1'b1;
        endcase
      end
    case (o)
      3'd0: tag = "R4";
      3'd1: tag = "R5";
      3'd2: tag = "R6";
      3'd6: tag = "R8";
      default: tag = "R7";
    endcase
    if (poke) tag = "R10";
    else if (w == 0) tag = "R1";
    else if (of < 0) tag = "R2";
    op = o; ofs = 32'(of); wsel = LW'(w); src = s; base = AW'(BASE); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1; op = 3'd5; ofs = 32'd0; wsel = 5'd1;
      end else begin
        start = 1'b0;
      end
    end
    if (cnt >= 200) begin
      n_chk++; n_err++;
      $display("FAIL R10 operation timeout: actual no done expected done");
    end
    check(tag, "result", 64'(result), 64'(eres));
    check(tag, "flag_src", 64'(flag), 64'(eflag));
    check("R3", "bytes read", 64'(rd_cnt), 64'(n));
    check("R9", "bytes written", 64'(wr_cnt), modify ? 64'(n) : 64'd0);
    check("R3", "address order", 64'(seq_err), 64'd0);
    for (int i = 0; i < 64; i++)
      if (mem[i] !== gold[i]) begin
        check(modify ? tag : "R9", "memory byte", 64'(mem[i]), 64'(gold[i]));
        break;
      end
    n_chk++;
  endtask

  int ofl [8] = '{-13, -8, -1, 0, 1, 7, 9, 22};

  initial begin
    int k;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; start = 1'b0; fill_req = 1'b0; clr_cnt = 1'b0; fill_seed = 0;
    op = '0; ofs = '0; wsel = '0; src = '0; base = '0; exp_start = '0;
    repeat (3) @(negedge clk);
    check("R10", "done in reset", 64'(done), 64'd0);
    check("R10", "mem_req in reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", "done after reset", 64'(done), 64'd0);
    check("R10", "mem_req after reset", 64'(mem_req), 64'd0);
    k = 1;
    for (int o = 0; o < 7; o++)
      for (int w = 0; w < 32; w++)
        for (int i = 0; i < 8; i++) begin
          run_case(k, 3'(o), ofl[i], w, 32'hA5C396E1 ^ (32'(k) * 32'h01010101), 1'b0);
          k++;
        end
    run_case(k, 3'd0, 5, 29, 32'h0, 1'b1);
    run_case(k + 1, 3'd2, -3, 17, 32'h0001D2B7, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule